// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans up one GPIO input before it is used for status readback and level or edge detection. The raw pin is first brought into the fast clock domain by a synchronizer. A slow real-time tick, delivered as a one-cycle enable pulse in the fast domain, drives the time base. Software picks the time unit (2, 8, 512 or 2048 ticks), a 4-bit count of units, and one of four filter modes. The cleaned level leaves the block on `pin_filt`.

In the symmetric mode, a new level is accepted only after it has been held for the full programmed time. The two one-sided modes let one kind of short pulse through at once and filter only the opposite direction. The preserve-low mode suits high-level interrupt sensing, and the preserve-high mode suits low-level sensing. When the mode field is zero, the synchronized pin passes straight through.

All pins are plain level or control signals. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure. Configuration inputs are sampled every cycle. Software should change them only while the pin is stable.

Top module: `dbf_filter`

## Requirements
- R1: While reset is asserted and after it is released, `pin_filt` is 0, because the synchronizer and the output register both clear to 0.
- R2: With `cfg_mode` = 0 (bypass), `pin_filt` follows `pin_raw` exactly 3 clock edges after the change: two synchronizer flops and one output flop. No tick is needed.
- R3: With `cfg_mode` = 1 (symmetric), a change of the synchronized level reaches `pin_filt` on the clock edge that samples the T-th tick after the change. T is count × unit length. The output is unchanged after T−1 ticks.
- R4: In any filtering mode, if the synchronized level returns to the output level before the timeout, the output does not change, the timer clears, and a later change must again wait the full T ticks.
- R5: The unit-select bits {`cfg_large`,`cfg_unit`} choose the unit length: 00 gives 2 ticks, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R6: A count of 0 with filtering enabled acts as a count of 1.
- R7: With `cfg_mode` = 2 (preserve low pulses), a falling level passes like bypass, with no tick needed. A rising level is filtered as in R3.
- R8: With `cfg_mode` = 3 (preserve high pulses), a rising level passes like bypass. A falling level is filtered as in R3.
- R9: Ticks that arrive while the input matches the output are not counted. Timing starts with the change itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle slow time-base pulse, synchronous to clk |
| pin_raw | input | 1 | Asynchronous raw pin level |
| cfg_mode | input | 2 | Filter mode: 0 bypass, 1 symmetric, 2 preserve low pulses, 3 preserve high pulses |
| cfg_count | input | 4 | Number of time units in the timeout (0 behaves as 1) |
| cfg_large | input | 1 | Unit select, upper bit |
| cfg_unit | input | 1 | Unit select, lower bit |
| pin_filt | output | 1 | Filtered pin level |

## Verification
The pin is driven with several patterns:
- A step held past the timeout separates an output that moves on the exact tick from one that moves a tick early or late.
- A pulse dropped before the timeout, followed by a fresh step, shows whether the glitch is suppressed and whether the timer really restarts.
- Runs of idle ticks before a step reveal a time base that keeps counting while the input is stable.
- Falling and rising steps in each one-sided mode separate the immediate direction from the filtered one.

Each unit select and a zero count are measured at their exact tick threshold.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic [1:0] {
    FILT_OFF       = 2'd0,
    FILT_BOTH      = 2'd1,
    FILT_KEEP_LOW  = 2'd2,
    FILT_KEEP_HIGH = 2'd3
  } filt_mode_e;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbf_prescale.sv
module dbf_prescale #(
  parameter int unsigned U0_LOG2 = 1,
  parameter int unsigned U1_LOG2 = 3,
  parameter int unsigned U2_LOG2 = 9,
  parameter int unsigned U3_LOG2 = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       unit_done
);
  localparam int unsigned PRE_W = dbf_pkg::max_of4(U0_LOG2, U1_LOG2, U2_LOG2, U3_LOG2) + 1;
  localparam int unsigned LOGS [4] = '{U0_LOG2, U1_LOG2, U2_LOG2, U3_LOG2};

  logic [PRE_W-1:0] cnt;
  logic [3:0]       at_end;

  for (genvar g = 0; g < 4; g++) begin : g_unit
    localparam logic [PRE_W-1:0] LAST = PRE_W'((1 << LOGS[g]) - 1);
    assign at_end[g] = (cnt == LAST);
  end

  logic last;
  assign last      = at_end[sel];
  assign unit_done = tick && last && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/dbf_timeout.sv
module dbf_timeout #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             unit_done,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] units;
  logic [CNT_W-1:0] target;

  assign target = (limit == '0) ? CNT_W'(1) : limit;
  assign expire = unit_done && (units == target - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          units <= '0;
    else if (clr)        units <= '0;
    else if (unit_done)  units <= expire ? '0 : units + 1'b1;
  end
endmodule

// File: rtl/dbf_filter.sv
module dbf_filter #(
  parameter int          SYNC_STAGES = 2,
  parameter int          CNT_W       = 4,
  parameter int unsigned U0_LOG2     = 1,
  parameter int unsigned U1_LOG2     = 3,
  parameter int unsigned U2_LOG2     = 9,
  parameter int unsigned U3_LOG2     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pin_raw,
  input  logic [1:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_large,
  input  logic             cfg_unit,
  output logic             pin_filt
);
  import dbf_pkg::*;

  filt_mode_e mode;
  logic       sync_lvl;
  logic       out_q;
  logic       rising, falling, take_now, pending;
  logic       unit_done, expire;

  assign mode = filt_mode_e'(cfg_mode);

  dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(sync_lvl)
  );

  assign rising  = sync_lvl && !out_q;
  assign falling = !sync_lvl && out_q;

  always_comb begin
    unique case (mode)
      FILT_OFF:       take_now = rising || falling;
      FILT_KEEP_LOW:  take_now = falling;
      FILT_KEEP_HIGH: take_now = rising;
      default:        take_now = 1'b0;
    endcase
  end

  assign pending = (rising || falling) && !take_now;

  dbf_prescale #(
    .U0_LOG2(U0_LOG2), .U1_LOG2(U1_LOG2), .U2_LOG2(U2_LOG2), .U3_LOG2(U3_LOG2)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(!pending), .tick(tick),
    .sel({cfg_large, cfg_unit}), .unit_done(unit_done)
  );

  dbf_timeout #(.CNT_W(CNT_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(!pending), .unit_done(unit_done),
    .limit(cfg_count), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          out_q <= 1'b0;
    else if (take_now || (pending && expire)) out_q <= sync_lvl;
  end

  assign pin_filt = out_q;
endmodule

// File: rtl/dbf_filter_chk.sv
module dbf_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [1:0] cfg_mode,
  input logic       sync_lvl,
  input logic       pin_filt
);
  // R4
  toward_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_filt != $past(pin_filt)) |-> (pin_filt == $past(sync_lvl)));

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0) |=> (pin_filt == $past(sync_lvl)));

  // R3
  both_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cfg_mode) == 2'd1) && (pin_filt != $past(pin_filt))) |-> $past(tick));

  // R7
  keep_low_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cfg_mode) == 2'd2) && $rose(pin_filt)) |-> $past(tick));

  // R7
  keep_low_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_mode == 2'd2) && pin_filt && !sync_lvl) |=> !pin_filt);

  // R8
  keep_high_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cfg_mode) == 2'd3) && $fell(pin_filt)) |-> $past(tick));
endmodule

bind dbf_filter dbf_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_mode(cfg_mode),
  .sync_lvl(sync_lvl), .pin_filt(pin_filt)
);

// File: tb/dbf_filter_test.sv
module dbf_filter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       pin_raw = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [3:0] cfg_count = 4'd0;
  logic       cfg_large = 1'b0;
  logic       cfg_unit = 1'b0;
  logic       pin_filt;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dbf_filter uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_raw(pin_raw),
    .cfg_mode(cfg_mode), .cfg_count(cfg_count), .cfg_large(cfg_large),
    .cfg_unit(cfg_unit), .pin_filt(pin_filt)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (pin_filt !== exp) begin
      failures++;
      $display("FAIL %s: pin_filt=%b expected=%b at %0t", req, pin_filt, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  // Drive the output to a known level through bypass, then set the config.
  task automatic prime(input logic lvl, input logic [1:0] m, input logic [3:0] c,
                       input logic [1:0] u);
    cfg_mode = 2'd0;
    pin_raw  = lvl;
    settle();
    cfg_mode  = m;
    cfg_count = c;
    {cfg_large, cfg_unit} = u;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(1'b0, "R1 reset level");
    rst_n = 1'b1;
    settle();
    check(1'b0, "R1 after release");
  endtask

  task automatic t_bypass();
    prime(1'b0, 2'd0, 4'd0, 2'd0);
    @(negedge clk) pin_raw = 1'b1;
    repeat (2) @(negedge clk);
    check(1'b0, "R2 latency not yet");
    @(negedge clk);
    check(1'b1, "R2 after three edges");
    pin_raw = 1'b0;
    settle();
    check(1'b0, "R2 follow fall");
  endtask

  task automatic t_remove();
    prime(1'b0, 2'd1, 4'd3, 2'b00);
    pin_raw = 1'b1;
    settle();
    check(1'b0, "R3 no tick yet");
    ticks(5);
    check(1'b0, "R3 one tick short");
    ticks(1);
    check(1'b1, "R3 rise accepted");
    pin_raw = 1'b0;
    settle();
    ticks(5);
    check(1'b1, "R3 fall one short");
    ticks(1);
    check(1'b0, "R3 fall accepted");
  endtask

  task automatic t_glitch();
    prime(1'b0, 2'd1, 4'd3, 2'b00);
    pin_raw = 1'b1;
    settle();
    ticks(4);
    pin_raw = 1'b0;
    settle();
    ticks(10);
    check(1'b0, "R4 glitch suppressed");
    pin_raw = 1'b1;
    settle();
    ticks(5);
    check(1'b0, "R4 timer restarted");
    ticks(1);
    check(1'b1, "R4 full time after restart");
  endtask

  task automatic t_unit(input logic [1:0] u, input logic [3:0] c, input int total);
    prime(1'b0, 2'd1, c, u);
    pin_raw = 1'b1;
    settle();
    ticks(total - 1);
    check(1'b0, "R5 unit one tick short");
    ticks(1);
    check(1'b1, "R5 unit threshold");
  endtask

  task automatic t_zero();
    prime(1'b0, 2'd1, 4'd0, 2'b00);
    pin_raw = 1'b1;
    settle();
    ticks(1);
    check(1'b0, "R6 zero count short");
    ticks(1);
    check(1'b1, "R6 zero count as one unit");
  endtask

  task automatic t_idle_ticks();
    prime(1'b0, 2'd1, 4'd2, 2'b00);
    ticks(7);
    pin_raw = 1'b1;
    settle();
    ticks(3);
    check(1'b0, "R9 idle ticks not counted");
    ticks(1);
    check(1'b1, "R9 timing from change");
  endtask

  task automatic t_keep_low();
    prime(1'b1, 2'd2, 4'd2, 2'b00);
    pin_raw = 1'b0;
    settle();
    check(1'b0, "R7 fall immediate");
    pin_raw = 1'b1;
    settle();
    ticks(3);
    check(1'b0, "R7 rise filtered");
    ticks(1);
    check(1'b1, "R7 rise accepted");
  endtask

  task automatic t_keep_high();
    prime(1'b0, 2'd3, 4'd2, 2'b00);
    pin_raw = 1'b1;
    settle();
    check(1'b1, "R8 rise immediate");
    pin_raw = 1'b0;
    settle();
    ticks(3);
    check(1'b1, "R8 fall filtered");
    ticks(1);
    check(1'b0, "R8 fall accepted");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_bypass();
    t_remove();
    t_glitch();
    t_unit(2'b00, 4'd2, 4);
    t_unit(2'b01, 4'd1, 8);
    t_unit(2'b10, 4'd1, 512);
    t_unit(2'b11, 4'd1, 2048);
    t_zero();
    t_idle_ticks();
    t_keep_low();
    t_keep_high();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule